// File: doc/BRIEF.md
# Triple-Channel Sample Switch Sequencer

This block produces the nine switch enables for a sampled front end in which three colour track/hold stages share one converter. The enables fall into four groups. Three clamp enables copy a clamp request. Two input-sampling enables and three channel-select enables are sequenced so that red, green and blue reach the converter in turn. One converter-sample enable pulses on every clock cycle. Channel changes happen on rising clock edges. The input-sampling window ends on the falling edge that follows its opening. The converter-sample enable is high during the high half of each clock period.

All enables come from flip-flops or from an XOR of flip-flops, so each enable changes only at a clock edge. At a channel handover the closing and opening selects change in the same register update, so there is never a half cycle with two channels selected. Synchronous reset opens every switch. The rotation then starts at red on the first rising edge that samples reset low.

Top module: `sw_tri_seq`

## Requirements
- R1: While reset is high, from the first rising edge that samples it onward, all nine enables (clamp_sw, in_smp_sw, chan_sw, conv_sw) read 0 in both clock phases, whatever clamp_in does.
- R2: clamp_sw holds the value of clamp_in sampled at the most recent rising edge, copied to all three bits (1 = closed). It does not change between rising edges.
- R3: On the first rising edge that samples reset low, chan_sw becomes 3'b001 (bit 0 = red) and both in_smp_sw bits become 1.
- R4: On each later rising edge the select moves red to green to blue to red: bit 0 to bit 1, bit 1 to bit 2, bit 2 to bit 0.
- R5: in_smp_sw closes (2'b11) only on the rising edge that selects red. It opens on the next falling edge and stays 2'b00 until red is selected again.
- R6: Once running, conv_sw goes to 1 on every rising edge and to 0 on every falling edge.
- R7: After the first rising edge following reset, exactly one chan_sw bit is set. At each handover the outgoing bit clears and the incoming bit sets on the same edge.
- R8: Changes on clamp_in have no effect on the channel rotation, the input-sampling enables or the converter-sample enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| clamp_in | input | 1 | Clamp request |
| clamp_sw | output | 3 | Clamp switch enables, 1 = closed |
| in_smp_sw | output | 2 | Input-sampling switch enables |
| chan_sw | output | 3 | Channel-select enables, bit 0 red, bit 1 green, bit 2 blue |
| conv_sw | output | 1 | Converter-sample switch enable |

## Verification
The select and clamp results change on the rising edge that samples the stimulus, so the bench reads them 1 ns after that edge. The input-sampling and converter-sample enables are read twice in every period: 1 ns after the rising edge, where they must be closed, and 1 ns after the falling edge, where they must be open. Stimulus is only changed 1 ns after a falling edge. This lets each rising edge be tied to exactly one expected phase, which the bench advances by itself through red, green and blue.

// File: rtl/sw_seq_pkg.sv
package sw_seq_pkg;
  localparam int unsigned SMP_SW_N = 2;
  typedef enum logic {SEQ_HALT = 1'b0, SEQ_RUN = 1'b1} run_e;
endpackage

// File: rtl/sw_chan_ring.sv
module sw_chan_ring #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [NUM_CH-1:0] chan_q,
  output logic              run_o,
  output logic              wrap_o
);
  import sw_seq_pkg::*;

  logic [NUM_CH-1:0] nxt;
  run_e              run_q;

  // bit 0 is entered from idle or from the last channel
  assign nxt[0] = chan_q[NUM_CH-1] | (chan_q == '0);
  for (genvar i = 1; i < NUM_CH; i++) begin : g_rot
    assign nxt[i] = chan_q[i-1];
  end

  assign wrap_o = ~rst & nxt[0];
  assign run_o  = (run_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      run_q  <= SEQ_HALT;
    end else begin
      chan_q <= nxt;
      run_q  <= SEQ_RUN;
    end
  end
endmodule

// File: rtl/sw_dual_edge.sv
module sw_dual_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         close_req,
  output logic [W-1:0] sw_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p_q;
    logic n_q;

    // rising edge opens a window by making p differ from n
    always_ff @(posedge clk) begin
      if (rst)            p_q <= 1'b0;
      else if (close_req) p_q <= ~n_q;
    end

    // falling edge closes the window by copying p
    always_ff @(negedge clk) begin
      if (rst) n_q <= 1'b0;
      else     n_q <= p_q;
    end

    assign sw_o[i] = (p_q ^ n_q) & run;
  end
endmodule

// File: rtl/sw_clamp_follow.sv
module sw_clamp_follow #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clamp_in,
  output logic [N-1:0] clamp_q
);
  always_ff @(posedge clk) begin
    if (rst) clamp_q <= '0;
    else     clamp_q <= {N{clamp_in}};
  end
endmodule

// File: rtl/sw_tri_seq.sv
module sw_tri_seq #(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_CLAMP = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               clamp_in,
  output logic [NUM_CLAMP-1:0]               clamp_sw,
  output logic [sw_seq_pkg::SMP_SW_N-1:0]    in_smp_sw,
  output logic [NUM_CH-1:0]                  chan_sw,
  output logic                               conv_sw
);
  import sw_seq_pkg::*;

  logic run;
  logic wrap;

  sw_chan_ring #(.NUM_CH(NUM_CH)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .chan_q(chan_sw),
    .run_o (run),
    .wrap_o(wrap)
  );

  sw_dual_edge #(.W(SMP_SW_N)) u_insmp (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .close_req(wrap),
    .sw_o     (in_smp_sw)
  );

  sw_dual_edge #(.W(1)) u_conv (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .close_req(~rst),
    .sw_o     (conv_sw)
  );

  sw_clamp_follow #(.N(NUM_CLAMP)) u_clamp (
    .clk     (clk),
    .rst     (rst),
    .clamp_in(clamp_in),
    .clamp_q (clamp_sw)
  );
endmodule

// File: rtl/sw_tri_seq_chk.sv
module sw_tri_seq_chk #(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_CLAMP = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            clamp_in,
  input logic [NUM_CLAMP-1:0]            clamp_sw,
  input logic [sw_seq_pkg::SMP_SW_N-1:0] in_smp_sw,
  input logic [NUM_CH-1:0]               chan_sw,
  input logic                            conv_sw
);
  logic [NUM_CH-1:0] rot;
  assign rot = {chan_sw[NUM_CH-2:0], chan_sw[NUM_CH-1]};

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_sw));

  // R4
  sel_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chan_sw) != '0) |-> (chan_sw == $past(rot)));

  // R3
  sel_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chan_sw) == '0) |-> (chan_sw == NUM_CH'(1)));

  // R5
  insmp_red_chk: assert property (@(negedge clk) disable iff (rst)
    (in_smp_sw != '0) |-> (chan_sw == NUM_CH'(1) && (&in_smp_sw)));

  // R6
  conv_high_chk: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> conv_sw);

  // R2
  clamp_copy_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (clamp_sw == {NUM_CLAMP{$past(clamp_in)}}));
endmodule

bind sw_tri_seq sw_tri_seq_chk #(.NUM_CH(NUM_CH), .NUM_CLAMP(NUM_CLAMP)) u_chk (.*);

// File: tb/sim_sw_tri_seq.sv
`timescale 1ns/1ps
module sim_sw_tri_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clamp_in = 1'b0;
  logic [2:0] clamp_sw;
  logic [1:0] in_smp_sw;
  logic [2:0] chan_sw;
  logic       conv_sw;
  int checks = 0;
  int errors = 0;
  int ph = 2;

  always #2.5 clk = ~clk;

  sw_tri_seq u0 (
    .clk(clk), .rst(rst), .clamp_in(clamp_in),
    .clamp_sw(clamp_sw), .in_smp_sw(in_smp_sw),
    .chan_sw(chan_sw), .conv_sw(conv_sw)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic at_high(); @(posedge clk); #1; endtask
  task automatic at_low();  @(negedge clk); #1; endtask

  task automatic all_open(string tag);
    chk({tag, " clamp"}, 8'(clamp_sw), 8'h0);
    chk({tag, " insmp"}, 8'(in_smp_sw), 8'h0);
    chk({tag, " chan"},  8'(chan_sw), 8'h0);
    chk({tag, " conv"},  8'(conv_sw), 8'h0);
  endtask

  // one period: rising edge then falling edge, starting and ending at low+1
  task automatic step(string tag);
    at_high();
    ph = (ph + 1) % 3;
    chk({tag, " chan@hi"},  8'(chan_sw), 8'(1 << ph));
    chk({tag, " insmp@hi"}, 8'(in_smp_sw), (ph == 0) ? 8'h3 : 8'h0);
    chk({tag, " conv@hi"},  8'(conv_sw), 8'h1);
    chk({tag, " onehot"},   8'($countones(chan_sw)), 8'h1);
    at_low();
    chk({tag, " chan@lo"},  8'(chan_sw), 8'(1 << ph));
    chk({tag, " insmp@lo"}, 8'(in_smp_sw), 8'h0);
    chk({tag, " conv@lo"},  8'(conv_sw), 8'h0);
  endtask

  task automatic t_reset();
    repeat (3) at_high();
    all_open("R1 hi");
    at_low();
    all_open("R1 lo");
    rst = 1'b0;
    ph = 2;
  endtask

  task automatic t_startup();
    step("R3");
    step("R5");
    step("R6");
  endtask

  task automatic t_rotation();
    for (int k = 0; k < 9; k++) step("R4/R7");
  endtask

  task automatic t_clamp();
    clamp_in = 1'b1;
    #0.5 chk("R2 before edge", 8'(clamp_sw), 8'h0);
    step("R8 clamp on");
    chk("R2 closed", 8'(clamp_sw), 8'h7);
    step("R8 clamp held");
    chk("R2 held", 8'(clamp_sw), 8'h7);
    clamp_in = 1'b0;
    step("R8 clamp off");
    chk("R2 opened", 8'(clamp_sw), 8'h0);
  endtask

  task automatic t_midreset();
    rst = 1'b1;
    clamp_in = 1'b1;
    at_high();
    all_open("R1 mid hi");
    at_low();
    all_open("R1 mid lo");
    at_high();
    at_low();
    all_open("R1 mid held");
    rst = 1'b0;
    clamp_in = 1'b0;
    ph = 2;
    step("R3 restart");
    chk("R2 after restart", 8'(clamp_sw), 8'h0);
    step("R4 restart");
    step("R4 restart2");
    step("R5 restart red");
  endtask

  initial begin
    t_reset();
    t_startup();
    t_rotation();
    t_clamp();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule